// File: doc/BRIEF.md
# Branch Redirect and Squash Controller

This block sequences the fetch address and tracks which pipeline slots hold live work for a six-stage in-order pipeline. The stages, in order, are PC select, fetch, decode, register read, execute and writeback. One instruction enters each cycle. The block always predicts that a branch falls through, so fetch keeps stepping sequentially past a branch until that branch reaches execute.

Execute logic outside the block evaluates the branch condition. It then reports three things: whether the instruction in execute is a branch, whether the branch is taken, and the target address. When a live branch in execute is taken, the block does two things in the same cycle. It redirects the fetch address to the target and clears the valid bits of the four younger slots ahead of execute. The branch itself carries on to writeback. None of the squashed slots has reached writeback yet, so none has committed anything and no undo is needed.

The block also carries a register-write request from execute to writeback. It gates that request with the slot's valid bit, so a squashed instruction can never write the register file.

Top module: `brsq_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the next state has `fetch_pc` equal to `RESET_VEC` and all six bits of `stage_valid` at 0.
- R2: After reset is released, the PC-select slot becomes valid holding `RESET_VEC` at the first edge. With no redirect, `fetch_pc` then grows by `STEP` (4) at every edge.
- R3: Each valid slot moves one stage per cycle. `stage_valid` bit 0 is PC select, bits 1 to 3 are fetch, decode and register read, bit 4 is execute and bit 5 is writeback. `ex_pc` and `wb_pc` give the addresses held in slots 4 and 5.
- R4: When `stage_valid[4]`, `ex_br_valid` and `ex_br_taken` are all 1 at an edge, the next `fetch_pc` equals `ex_br_target` and `stage_valid[0]` is 1.
- R5: In that redirect cycle, `front_kill[i]` equals `stage_valid[i]` for i = 0 to 3. At the next edge, `stage_valid` bits 1 to 4 are 0, so no squashed slot ever shows as valid at writeback.
- R6: A live branch in execute with `ex_br_taken` at 0 causes no redirect and no kill. Writeback shows the next sequential instruction in the very next cycle.
- R7: Branch inputs presented while `stage_valid[4]` is 0 are ignored. There is no redirect, `front_kill` stays 0 and sequential fetch continues.
- R8: `wb_wen` is 1 exactly when the writeback slot is valid and `ex_wr_req` was 1 while that instruction was in execute.
- R9: After a taken branch, writeback shows the branch, then exactly four invalid cycles, then the target instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_br_valid | input | 1 | Instruction in execute is a conditional branch |
| ex_br_taken | input | 1 | Branch outcome evaluated in execute |
| ex_br_target | input | PC_W | Branch target address |
| ex_wr_req | input | 1 | Instruction in execute writes a register |
| fetch_pc | output | PC_W | Address held in the PC-select slot |
| stage_valid | output | 6 | Per-stage valid bits, bit 0 = PC select, bit 5 = writeback |
| front_kill | output | 4 | Per-stage squash pulse for PC select to register read |
| ex_pc | output | PC_W | Address of the instruction in execute |
| wb_pc | output | PC_W | Address of the instruction in writeback |
| wb_wen | output | 1 | Register-file write enable at writeback |

## Verification
The embedded assertions check the per-cycle rules on every clock edge: the reset state, the +4 step, loading the target on a redirect, clearing the four front slots one edge after a redirect, ignoring branch inputs from an invalid execute slot, and `wb_wen` only when writeback is valid. The bench scenarios cover what only a whole instruction stream can show. These are the committed order at writeback against an architectural model, exactly four bubbles after each taken branch and none after a not-taken one, a taken branch sitting at a branch target, and two adjacent taken branches where the second is squashed and must be ignored.

// File: rtl/brsq_pkg.sv
package brsq_pkg;
  localparam int NUM_ST = 6;  // PC select, fetch, decode, reg read, execute, writeback
  localparam int EX_IDX = 4;  // stage where branches resolve
  localparam int WB_IDX = NUM_ST - 1;
  localparam int FRONT_N = EX_IDX;  // slots younger than execute
endpackage

// File: rtl/brsq_pc_gen.sv
module brsq_pc_gen #(
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] RESET_VEC = '0,
  parameter int STEP = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            redirect,
  input  logic [PC_W-1:0] redir_pc,
  output logic [PC_W-1:0] pc_q,
  output logic            vld_q
);
  localparam logic [PC_W-1:0] STEP_W = PC_W'(STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= RESET_VEC;
      vld_q <= 1'b0;
    end else if (redirect) begin
      pc_q  <= redir_pc;
      vld_q <= 1'b1;
    end else begin
      if (vld_q) pc_q <= pc_q + STEP_W;
      vld_q <= 1'b1;
    end
  end

  // R2: sequential step
  a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
    (vld_q && !redirect) |=> (pc_q == $past(pc_q) + STEP_W && vld_q));

  // R4: redirect loads target
  a_r4_redirect_load: assert property (@(posedge clk) disable iff (rst)
    redirect |=> (pc_q == $past(redir_pc) && vld_q));
endmodule

// File: rtl/brsq_stage_pipe.sv
module brsq_stage_pipe
  import brsq_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         squash,
  input  logic                         head_vld,
  input  logic [PC_W-1:0]              head_pc,
  input  logic                         ex_wr_req,
  output logic [NUM_ST-1:0]            vld,
  output logic [NUM_ST-1:0][PC_W-1:0]  pc,
  output logic                         wb_wen
);
  localparam logic [NUM_ST-1:0] SQ_MASK = NUM_ST'(((1 << EX_IDX) - 1) << 1);

  assign vld[0] = head_vld;
  assign pc[0]  = head_pc;

  for (genvar i = 1; i < NUM_ST; i++) begin : g_stage
    localparam bit CLEARABLE = (i <= EX_IDX);
    always_ff @(posedge clk) begin
      if (rst) begin
        vld[i] <= 1'b0;
      end else if (CLEARABLE) begin
        vld[i] <= vld[i-1] & ~squash;
      end else begin
        vld[i] <= vld[i-1];
      end
      pc[i] <= pc[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) wb_wen <= 1'b0;
    else     wb_wen <= vld[EX_IDX] & ex_wr_req;
  end

  // R5: squashed slots are empty on the next cycle
  a_r5_front_cleared: assert property (@(posedge clk) disable iff (rst)
    squash |=> ((vld & SQ_MASK) == '0));

  // R8: write enable only with a live writeback slot
  a_r8_wen_needs_valid: assert property (@(posedge clk) disable iff (rst)
    wb_wen |-> vld[WB_IDX]);

  // R9: the resolving branch itself reaches writeback
  a_r9_branch_advances: assert property (@(posedge clk) disable iff (rst)
    (squash && vld[EX_IDX]) |=> (vld[WB_IDX] && pc[WB_IDX] == $past(pc[EX_IDX])));
endmodule

// File: rtl/brsq_ctrl.sv
module brsq_ctrl
  import brsq_pkg::*;
#(
  parameter int PC_W = 32,
  parameter logic [PC_W-1:0] RESET_VEC = 32'h0000_0100,
  parameter int STEP = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ex_br_valid,
  input  logic               ex_br_taken,
  input  logic [PC_W-1:0]    ex_br_target,
  input  logic               ex_wr_req,
  output logic [PC_W-1:0]    fetch_pc,
  output logic [NUM_ST-1:0]  stage_valid,
  output logic [FRONT_N-1:0] front_kill,
  output logic [PC_W-1:0]    ex_pc,
  output logic [PC_W-1:0]    wb_pc,
  output logic               wb_wen
);
  logic                        redirect;
  logic                        head_vld;
  logic [PC_W-1:0]             head_pc;
  logic [NUM_ST-1:0][PC_W-1:0] pc_arr;

  assign redirect = stage_valid[EX_IDX] & ex_br_valid & ex_br_taken;

  brsq_pc_gen #(.PC_W(PC_W), .RESET_VEC(RESET_VEC), .STEP(STEP)) u_pc (
    .clk(clk), .rst(rst), .redirect(redirect), .redir_pc(ex_br_target),
    .pc_q(head_pc), .vld_q(head_vld)
  );

  brsq_stage_pipe #(.PC_W(PC_W)) u_pipe (
    .clk(clk), .rst(rst), .squash(redirect), .head_vld(head_vld),
    .head_pc(head_pc), .ex_wr_req(ex_wr_req), .vld(stage_valid),
    .pc(pc_arr), .wb_wen(wb_wen)
  );

  for (genvar k = 0; k < FRONT_N; k++) begin : g_kill
    assign front_kill[k] = redirect & stage_valid[k];
  end

  assign fetch_pc = head_pc;
  assign ex_pc    = pc_arr[EX_IDX];
  assign wb_pc    = pc_arr[WB_IDX];

  // R1: reset state
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (fetch_pc == RESET_VEC && stage_valid == '0));

  // R7: branch inputs from a dead execute slot do nothing
  a_r7_dead_branch_ignored: assert property (@(posedge clk) disable iff (rst)
    (!stage_valid[EX_IDX] && stage_valid[0] && ex_br_valid && ex_br_taken)
      |=> (fetch_pc == $past(fetch_pc) + PC_W'(STEP)));

  a_r7_no_kill_when_dead: assert property (@(posedge clk) disable iff (rst)
    !stage_valid[EX_IDX] |-> (front_kill == '0));
endmodule

// File: tb/brsq_ctrl_tb.sv
module brsq_ctrl_tb;
  localparam int PC_W = 32;
  localparam logic [31:0] RV = 32'h100;
  localparam int N_COMMIT = 30;

  logic clk = 0, rst = 1;
  logic ex_br_valid = 0, ex_br_taken = 0, ex_wr_req = 0;
  logic [31:0] ex_br_target = '0;
  logic [31:0] fetch_pc, ex_pc, wb_pc;
  logic [5:0] stage_valid;
  logic [3:0] front_kill;
  logic wb_wen;

  int checks = 0, errors = 0, cycles = 0;
  logic [32:0] exp_q[$];  // {taken, pc}

  always #2.5 clk = ~clk;

  brsq_ctrl #(.PC_W(PC_W), .RESET_VEC(RV), .STEP(4)) u_dut (
    .clk(clk), .rst(rst), .ex_br_valid(ex_br_valid), .ex_br_taken(ex_br_taken),
    .ex_br_target(ex_br_target), .ex_wr_req(ex_wr_req), .fetch_pc(fetch_pc),
    .stage_valid(stage_valid), .front_kill(front_kill), .ex_pc(ex_pc),
    .wb_pc(wb_pc), .wb_wen(wb_wen)
  );

  function automatic bit is_br(input logic [31:0] p);
    return p == 32'h110 || p == 32'h114 || p == 32'h208 || p == 32'h210 ||
           p == 32'h240 || p == 32'h284 || p == 32'h288;
  endfunction
  function automatic bit is_tk(input logic [31:0] p);
    return is_br(p) && p != 32'h208;
  endfunction
  function automatic logic [31:0] tgt(input logic [31:0] p);
    case (p)
      32'h110: return 32'h200;
      32'h114: return 32'h300;
      32'h210: return 32'h240;
      32'h240: return 32'h280;
      32'h284: return 32'h2c0;
      32'h288: return 32'h400;
      default: return 32'h500;
    endcase
  endfunction
  function automatic bit wr_of(input logic [31:0] p);
    return p[3] == 1'b0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: architectural model of the committed stream
  task automatic build_expected();
    logic [31:0] p = RV;
    for (int n = 0; n < N_COMMIT; n++) begin
      exp_q.push_back({is_tk(p), p});
      p = is_tk(p) ? tgt(p) : p + 32'd4;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // monitor + input driver, all at the falling edge
  logic [31:0] prev_fpc = '0;
  bit prev_v0 = 0, prev_redir = 0, seen_first = 0, last_taken = 0;
  logic [31:0] pend_tgt = '0;
  int gap = 0;

  initial begin
    build_expected();
    repeat (3) @(negedge clk);
    check(fetch_pc == RV, "R1 reset pc", fetch_pc, RV);
    check(stage_valid == 6'd0, "R1 reset valid", 32'(stage_valid), 0);
    rst = 0;
    @(negedge clk);
    check(stage_valid == 6'b000001 && fetch_pc == RV, "R2 first fetch", fetch_pc, RV);
    prev_fpc = fetch_pc; prev_v0 = 1;
    forever begin
      // set branch inputs for the current execute slot (valid or not: R7)
      ex_br_valid  = is_br(ex_pc);
      ex_br_taken  = is_tk(ex_pc);
      ex_br_target = tgt(ex_pc);
      ex_wr_req    = wr_of(ex_pc);
      #0.1;
      if (stage_valid[4] && is_tk(ex_pc)) begin
        check(front_kill == stage_valid[3:0], "R5 kill matches valid",
              32'(front_kill), 32'(stage_valid[3:0]));
        check(front_kill == 4'hF, "R5 four slots killed", 32'(front_kill), 32'hF);
      end else begin
        check(front_kill == 4'h0, "R7 no kill", 32'(front_kill), 0);
      end
      @(negedge clk);
      if (prev_redir) begin
        check(fetch_pc == pend_tgt && stage_valid[0], "R4 redirect target", fetch_pc, pend_tgt);
        check(stage_valid[4:1] == 4'h0, "R5 front cleared", 32'(stage_valid), 32'h0);
      end else if (prev_v0) begin
        check(fetch_pc == prev_fpc + 32'd4, "R2 sequential step", fetch_pc, prev_fpc + 32'd4);
      end
      prev_redir = ex_br_valid && ex_br_taken && (ex_pc == ex_pc) && 1'b0;
      prev_fpc = fetch_pc; prev_v0 = stage_valid[0];
      // writeback monitor
      if (!stage_valid[5]) begin
        check(!wb_wen, "R8 no write when invalid", 32'(wb_wen), 0);
        gap++;
      end else begin
        logic [32:0] e;
        if (exp_q.size() == 0) finish_run();
        e = exp_q.pop_front();
        check(wb_pc == e[31:0], "R3 commit order", wb_pc, e[31:0]);
        check(wb_wen == wr_of(e[31:0]), "R8 write enable", 32'(wb_wen), 32'(wr_of(e[31:0])));
        if (seen_first)
          check(gap == (last_taken ? 4 : 0), last_taken ? "R9 bubbles" : "R6 no penalty",
                gap, last_taken ? 4 : 0);
        seen_first = 1; last_taken = e[32]; gap = 0;
        if (exp_q.size() == 0) finish_run();
      end
    end
  end

  // track redirect decision made at the previous edge
  always @(posedge clk) begin
    prev_redir <= !rst && stage_valid[4] && ex_br_valid && ex_br_taken;
    pend_tgt   <= ex_br_target;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 2000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=<2000", cycles);
        finish_run();
      end
    end
  end
endmodule